// File: doc/BRIEF.md
# Lock-Aware Glitch-Free Clock Bypass Selector

This block picks the clock that leaves a PLL subsystem. It can pass the PLL reference clock, pass the PLL output clock, or hold its output low with no clock. The choice follows a 2-bit mode, a lock indicator and a master enable. A change of choice is made through an enable handshake between the two clock domains, so the output never carries a shortened pulse, and the choice can change while the PLL runs.

All three control inputs are asynchronous. They are synchronized into the reference domain, where one committed selection is kept. The committed selection only moves on once the previous handoff has been confirmed in both domains. Each source has its own enable flop on the falling edge of its own clock. A source is switched on only after the other source's enable has been seen low through a synchronizer. A busy flag reports a handoff in progress. A separate flag tells the PLL control that, with the enable low, the selector has already settled on its disabled-state choice, so the PLL circuit can be powered down.

Top module: `clk_bypass_sel`

## Requirements
- R1: While reset is asserted, and just after it is released, `clk_o` is held low.
- R2: Mode 0 (auto) with enable high passes the reference clock while lock is low, and the PLL clock once lock is high.
- R3: Mode 0 with enable low passes the reference clock whatever the lock state.
- R4: Mode 1 (lock-gated) with enable high passes the PLL clock while lock is high, and holds `clk_o` low while lock is low.
- R5: Modes 1 and 3 with enable low hold `clk_o` low.
- R6: Mode 2 (forced reference) passes the reference clock regardless of lock and enable.
- R7: Mode 3 (forced PLL) with enable high passes the PLL clock regardless of lock.
- R8: The two source enables are never high together, and `clk_o` is never high while both source clocks are low, including during a switch.
- R9: `busy_o` goes high within two reference cycles of a change that alters the selection, and stays high until the handoff is confirmed. It is low once the output is steady on its selection.
- R10: `pll_off_ok_o` is high only when the enable is low, the selector has settled on the disabled-state choice, and the PLL clock is gated. It is low whenever the enable is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | PLL reference clock |
| pll_clk | input | 1 | PLL output clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lock_i | input | 1 | Lock indicator, asynchronous |
| en_i | input | 1 | PLL master enable, asynchronous |
| mode_i | input | 2 | Mode: 0 auto, 1 lock-gated, 2 forced reference, 3 forced PLL |
| clk_o | output | 1 | Selected output clock |
| busy_o | output | 1 | Handoff in progress (reference domain) |
| pll_off_ok_o | output | 1 | Disabled-state selection reached; PLL circuit may be switched off |

## Verification
The assertions assume that both source clocks keep toggling whenever a handoff involves them. They also assume that the control inputs do not change again before the previous handoff has settled, since the handshake only confirms one transition at a time. The stimulus keeps both clocks free-running at unrelated periods throughout. It holds every control setting for many tens of reference cycles before it judges the output or applies the next setting.

// File: rtl/cbs_pkg.sv
`timescale 1ns/1ps
package cbs_pkg;
  typedef enum logic [1:0] {
    MODE_AUTO      = 2'd0,
    MODE_LOCK_GATE = 2'd1,
    MODE_FORCE_REF = 2'd2,
    MODE_FORCE_PLL = 2'd3
  } sel_mode_e;

  typedef enum logic [1:0] {
    SRC_NONE = 2'd0,
    SRC_REF  = 2'd1,
    SRC_PLL  = 2'd2
  } src_e;
endpackage

// File: rtl/cbs_sync.sv
`timescale 1ns/1ps
module cbs_sync #(
  parameter int STAGES = 2,
  parameter int WIDTH  = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  localparam int CHAIN_W = STAGES * WIDTH;

  logic [CHAIN_W-1:0] chain_q;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= d;
      end
    end else begin : g_multi
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= {chain_q[CHAIN_W-WIDTH-1:0], d};
      end
    end
  endgenerate

  assign q = chain_q[CHAIN_W-1 -: WIDTH];
endmodule

// File: rtl/cbs_decode.sv
`timescale 1ns/1ps
module cbs_decode
  import cbs_pkg::*;
(
  input  sel_mode_e mode,
  input  logic      lock,
  input  logic      en,
  output src_e      tgt
);
  always_comb begin
    unique case (mode)
      MODE_AUTO:      tgt = (en && lock) ? SRC_PLL : SRC_REF;
      MODE_LOCK_GATE: tgt = (en && lock) ? SRC_PLL : SRC_NONE;
      MODE_FORCE_REF: tgt = SRC_REF;
      default:        tgt = en ? SRC_PLL : SRC_NONE;
    endcase
  end
endmodule

// File: rtl/cbs_gate.sv
`timescale 1ns/1ps
module cbs_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic want,
  input  logic other_seen,
  output logic en_q
);
  // Enable changes only while this source clock is low.
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) en_q <= 1'b0;
    else        en_q <= want & ~other_seen;
  end
endmodule

// File: rtl/clk_bypass_sel.sv
`timescale 1ns/1ps
module clk_bypass_sel
  import cbs_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       ref_clk,
  input  logic       pll_clk,
  input  logic       rst_n,
  input  logic       lock_i,
  input  logic       en_i,
  input  logic [1:0] mode_i,
  output logic       clk_o,
  output logic       busy_o,
  output logic       pll_off_ok_o
);
  localparam int REF_VIEW_W = 5;
  localparam int PLL_VIEW_W = 2;

  logic [REF_VIEW_W-1:0] ref_view;
  logic [PLL_VIEW_W-1:0] pll_view;
  logic      ref_en_q, pll_en_q;
  logic      pll_en_seen, en_s, lock_s;
  sel_mode_e mode_s;
  src_e      tgt, cur_q;
  logic      settled;

  // Reference domain view of controls and of the PLL-side enable
  cbs_sync #(.STAGES(SYNC_STAGES), .WIDTH(REF_VIEW_W)) u_ref_sync (
    .clk(ref_clk), .rst_n(rst_n),
    .d({pll_en_q, en_i, lock_i, mode_i}), .q(ref_view)
  );
  assign pll_en_seen = ref_view[4];
  assign en_s        = ref_view[3];
  assign lock_s      = ref_view[2];
  assign mode_s      = sel_mode_e'(ref_view[1:0]);

  cbs_decode u_dec (.mode(mode_s), .lock(lock_s), .en(en_s), .tgt(tgt));

  // Committed selection advances only after the last handoff is confirmed
  assign settled = (ref_en_q    == (cur_q == SRC_REF)) &&
                   (pll_en_seen == (cur_q == SRC_PLL));

  always_ff @(posedge ref_clk or negedge rst_n) begin
    if (!rst_n)                       cur_q <= SRC_NONE;
    else if (settled && tgt != cur_q) cur_q <= tgt;
  end

  cbs_gate u_ref_gate (
    .clk(ref_clk), .rst_n(rst_n),
    .want(cur_q == SRC_REF), .other_seen(pll_en_seen), .en_q(ref_en_q)
  );

  // PLL domain view of the request and of the reference-side enable
  cbs_sync #(.STAGES(SYNC_STAGES), .WIDTH(PLL_VIEW_W)) u_pll_sync (
    .clk(pll_clk), .rst_n(rst_n),
    .d({cur_q == SRC_PLL, ref_en_q}), .q(pll_view)
  );

  cbs_gate u_pll_gate (
    .clk(pll_clk), .rst_n(rst_n),
    .want(pll_view[1]), .other_seen(pll_view[0]), .en_q(pll_en_q)
  );

  assign clk_o        = (ref_clk & ref_en_q) | (pll_clk & pll_en_q);
  assign busy_o       = !settled || (tgt != cur_q);
  assign pll_off_ok_o = !en_s && !busy_o;
endmodule

// File: rtl/cbs_checker.sv
`timescale 1ns/1ps
module cbs_checker (
  input logic       ref_clk,
  input logic       pll_clk,
  input logic       rst_n,
  input logic       clk_o,
  input logic       busy_o,
  input logic       pll_off_ok_o,
  input logic       ref_en_q,
  input logic       pll_en_q,
  input logic [1:0] cur_q
);
  always @(posedge ref_clk) begin
    if (!rst_n) begin
      p_reset_low_r1: assert (!clk_o) else $error("R1 clock active in reset");
    end
  end

  p_excl_ref_r8: assert property (@(posedge ref_clk) disable iff (!rst_n)
    !(ref_en_q && pll_en_q));

  p_excl_pll_r8: assert property (@(posedge pll_clk) disable iff (!rst_n)
    !(ref_en_q && pll_en_q));

  p_idle_match_r9: assert property (@(posedge ref_clk) disable iff (!rst_n)
    !busy_o |-> ((ref_en_q == (cur_q == 2'd1)) && (pll_en_q == (cur_q == 2'd2))));

  p_off_gated_r10: assert property (@(posedge ref_clk) disable iff (!rst_n)
    pll_off_ok_o |-> !pll_en_q);
endmodule

bind clk_bypass_sel cbs_checker u_chk (
  .ref_clk(ref_clk), .pll_clk(pll_clk), .rst_n(rst_n), .clk_o(clk_o),
  .busy_o(busy_o), .pll_off_ok_o(pll_off_ok_o), .ref_en_q(ref_en_q),
  .pll_en_q(pll_en_q), .cur_q(cur_q)
);

// File: tb/clk_bypass_sel_tb.sv
`timescale 1ns/1ps
module clk_bypass_sel_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int PLL_PERIOD = 6;
  localparam int SRC_NONE = 0, SRC_REF = 1, SRC_PLL = 2;

  logic ref_clk = 1'b0, pll_clk = 1'b0, rst_n = 1'b0;
  logic lock_i = 1'b0, en_i = 1'b0;
  logic [1:0] mode_i = 2'd0;
  logic clk_o, busy_o, pll_off_ok_o;
  int n_checks = 0, n_fails = 0;

  clk_bypass_sel dut_i (
    .ref_clk(ref_clk), .pll_clk(pll_clk), .rst_n(rst_n), .lock_i(lock_i),
    .en_i(en_i), .mode_i(mode_i), .clk_o(clk_o), .busy_o(busy_o),
    .pll_off_ok_o(pll_off_ok_o)
  );

  always #(CLK_PERIOD/2) ref_clk = ~ref_clk;
  always #(PLL_PERIOD/2) pll_clk = ~pll_clk;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s: %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic apply(input int mode, input bit en, input bit lock);
    mode_i = mode[1:0]; en_i = en; lock_i = lock;
  endtask

  // Wait for settling, then compare clk_o against the expected source
  task automatic expect_src(input int exp, input string req);
    int mism = 0;
    repeat (60) @(posedge ref_clk);
    #0.5;
    for (int i = 0; i < 120; i++) begin
      logic want;
      want = (exp == SRC_REF) ? ref_clk : (exp == SRC_PLL) ? pll_clk : 1'b0;
      if (clk_o !== want) mism++;
      #1;
    end
    check(mism == 0, req, $sformatf("output source %0d mismatches", exp), mism, 0);
    check(busy_o == 1'b0, "R9", "busy after settling", busy_o, 0);
  endtask

  // Watch a switch: busy must rise, output never high with both sources low
  task automatic watch_switch(input string req);
    int bad = 0;
    int busy_seen = 0;
    @(posedge ref_clk);
    #0.5;
    for (int i = 0; i < 400; i++) begin
      if (clk_o && !ref_clk && !pll_clk) bad++;
      if (i == 30) busy_seen = busy_o;
      #0.5;
    end
    check(bad == 0, "R8", {"spurious high during switch, ", req}, bad, 0);
    check(busy_seen == 1, "R9", {"busy during handoff, ", req}, busy_seen, 1);
  endtask

  task automatic t_reset;
    int hi = 0;
    apply(0, 1'b0, 1'b0);
    for (int i = 0; i < 60; i++) begin
      #1;
      if (clk_o) hi++;
    end
    check(hi == 0, "R1", "clk_o high during reset", hi, 0);
    @(negedge ref_clk);
    rst_n = 1'b1;
    #1;
    check(clk_o == 1'b0, "R1", "clk_o just after reset release", clk_o, 0);
    expect_src(SRC_REF, "R3");
    check(pll_off_ok_o == 1'b1, "R10", "off-ok with enable low", pll_off_ok_o, 1);
  endtask

  task automatic t_auto;
    apply(0, 1'b1, 1'b0);
    expect_src(SRC_REF, "R2");
    check(pll_off_ok_o == 1'b0, "R10", "off-ok with enable high", pll_off_ok_o, 0);
    apply(0, 1'b1, 1'b1);
    watch_switch("auto lock");
    expect_src(SRC_PLL, "R2");
    apply(0, 1'b0, 1'b1);
    watch_switch("auto disable");
    expect_src(SRC_REF, "R3");
    check(pll_off_ok_o == 1'b1, "R10", "off-ok auto disabled", pll_off_ok_o, 1);
  endtask

  task automatic t_lock_gate;
    apply(1, 1'b1, 1'b1);
    watch_switch("gated lock");
    expect_src(SRC_PLL, "R4");
    check(pll_off_ok_o == 1'b0, "R10", "off-ok mode1 enabled", pll_off_ok_o, 0);
    apply(1, 1'b1, 1'b0);
    watch_switch("gated unlock");
    expect_src(SRC_NONE, "R4");
    apply(1, 1'b1, 1'b1);
    expect_src(SRC_PLL, "R4");
    apply(1, 1'b0, 1'b1);
    watch_switch("gated disable");
    expect_src(SRC_NONE, "R5");
    check(pll_off_ok_o == 1'b1, "R10", "off-ok mode1 disabled", pll_off_ok_o, 1);
  endtask

  task automatic t_force_ref;
    apply(2, 1'b1, 1'b1);
    watch_switch("force ref");
    expect_src(SRC_REF, "R6");
    apply(2, 1'b1, 1'b0);
    expect_src(SRC_REF, "R6");
    apply(2, 1'b0, 1'b1);
    expect_src(SRC_REF, "R6");
  endtask

  task automatic t_force_pll;
    apply(3, 1'b1, 1'b0);
    watch_switch("force pll");
    expect_src(SRC_PLL, "R7");
    apply(3, 1'b1, 1'b1);
    expect_src(SRC_PLL, "R7");
    apply(3, 1'b0, 1'b0);
    watch_switch("force pll disable");
    expect_src(SRC_NONE, "R5");
    check(pll_off_ok_o == 1'b1, "R10", "off-ok mode3 disabled", pll_off_ok_o, 1);
  endtask

  initial begin
    t_reset();
    t_auto();
    t_lock_gate();
    t_force_ref();
    t_force_pll();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    n_fails++;
    $display("FAIL watchdog: run did not complete actual=1 expected=0");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end
endmodule